// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

This block is a free-running time base. It divides the resonator-rate clock by a fixed prescale factor and uses the result to advance a 10-bit counter. With the default factor of six and a 6 MHz resonator, the counter moves once per microsecond. The low byte of the counter is always available as read data for the timer's I/O read address. The bus decoder outside the block selects it. Software cannot write the counter, and no write path to it exists.

Two periodic tick pulses come from the counter's carries. The fast tick fires each time the low seven bits roll over, which is every 128 counts (128 µs). The slow tick fires each time the full 10-bit counter wraps, which is every 1024 counts (1.024 ms). The slow tick also serves as the clock for a watchdog elsewhere.

A power-on reset clears the counter and the prescaler phase. A one-cycle suspend-entry strobe clears them as well. While the chip is suspended, a clock-gate enable is held low. This freezes all state, and counting picks up again on the first enabled cycle.

Top module: `interval_timer`

## Requirements
- R1: The counter advances by exactly one after every sixth enabled cycle (PRESCALE = 6). Enabled means run_en high and suspend_enter low. The prescaler phase runs 0..5 and the counter steps on the edge that takes the phase from 5 back to 0.
- R2: timer_rdata equals bits 7..0 of the 10-bit counter at all times. The counter wraps from 1023 to 0, so timer_rdata shows 0 again after 255.
- R3: While rst_n is low, the counter and prescaler phase are cleared at once (asynchronously), and timer_rdata, tick_fast and tick_slow are 0.
- R4: tick_fast is high for exactly one cycle, in the cycle where the counter first shows a multiple of 128 after a step. That is every 768 enabled cycles from a cleared state.
- R5: tick_slow is high for exactly one cycle, in the cycle where the counter first shows 0 after a step from 1023. That is every 6144 enabled cycles from a cleared state. tick_fast is high in that same cycle.
- R6: A suspend_enter pulse clears the counter and prescaler phase on the next rising edge, whatever the value of run_en. No tick is raised for that edge.
- R7: While run_en is low, the counter and prescaler phase hold their values and both ticks stay 0.
- R8: When run_en returns high, counting resumes at once from the held prescaler phase, with no extra delay and no lost phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Resonator-rate clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| suspend_enter | input | 1 | One-cycle strobe marking entry into suspend; clears the timer |
| run_en | input | 1 | Clock-gate enable; low while suspended |
| timer_rdata | output | 8 | Low byte of the counter, read-only data for the timer address |
| tick_fast | output | 1 | One-cycle pulse every 128 counts |
| tick_slow | output | 1 | One-cycle pulse every 1024 counts (watchdog time base) |

## Verification
An enabled cycle moves the prescaler phase on its rising edge. timer_rdata therefore changes on the same edge that completes the sixth enabled cycle. Each tick is registered next to the counter, so it goes high in the same cycle the new boundary count appears. A suspend strobe clears everything by the following edge, and reset clears it with no clock at all. The bench model advances on the same rising edge as the design, and it follows reset asynchronously just as the design does. All outputs are compared at the falling edge that follows, so every expected value is sampled after exactly one register stage.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Next prescaler phase: modulo-span increment.
  function automatic int unsigned phase_after(input int unsigned ph, input int unsigned span);
    return (ph + 1 >= span) ? 0 : ph + 1;
  endfunction

  // True on the phase whose next step produces a counter increment.
  function automatic bit is_last_phase(input int unsigned ph, input int unsigned span);
    return ph == span - 1;
  endfunction

  // True when the lowest nbits of v are all ones (a carry leaves them on increment).
  function automatic bit low_bits_full(input int unsigned v, input int unsigned nbits);
    int unsigned mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PRESCALE = 6,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic step
);
  import itmr_pkg::*;

  logic [PW-1:0] phase_q;
  logic          advance;

  assign advance = run && !clear;
  assign step    = advance && is_last_phase(32'(phase_q), PRESCALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= PW'(phase_after(32'(phase_q), PRESCALE));
    end
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
  parameter int CNT_W     = 10,
  parameter int SPAN_BITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  output logic             tick
);
  import itmr_pkg::*;

  logic tick_q;
  logic carry_out;

  // A carry leaves the low SPAN_BITS on this step.
  assign carry_out = step && low_bits_full(32'(count), SPAN_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= carry_out && !clear;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PRESCALE       = 6,
  parameter int CNT_W          = 10,
  parameter int RD_W           = 8,
  parameter int FAST_SPAN_BITS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            suspend_enter,
  input  logic            run_en,
  output logic [RD_W-1:0] timer_rdata,
  output logic            tick_fast,
  output logic            tick_slow
);
  localparam int NTICK = 2;
  localparam int TICK_SPAN [NTICK] = '{FAST_SPAN_BITS, CNT_W};

  // Named internal events, visible to the bound checker.
  logic             step_evt;
  logic [CNT_W-1:0] cnt_val;
  logic [NTICK-1:0] tick_vec;

  itmr_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (suspend_enter),
    .run   (run_en),
    .step  (step_evt)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (suspend_enter),
    .step  (step_evt),
    .count (cnt_val)
  );

  for (genvar gi = 0; gi < NTICK; gi++) begin : g_tick
    itmr_tick_gen #(.CNT_W(CNT_W), .SPAN_BITS(TICK_SPAN[gi])) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (suspend_enter),
      .step  (step_evt),
      .count (cnt_val),
      .tick  (tick_vec[gi])
    );
  end

  assign timer_rdata = cnt_val[RD_W-1:0];
  assign tick_fast   = tick_vec[0];
  assign tick_slow   = tick_vec[1];
endmodule

// File: rtl/interval_timer_sva.sv
module interval_timer_sva #(
  parameter int CNT_W          = 10,
  parameter int RD_W           = 8,
  parameter int FAST_SPAN_BITS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             suspend_enter,
  input logic             run_en,
  input logic             step_evt,
  input logic [CNT_W-1:0] cnt_val,
  input logic [RD_W-1:0]  timer_rdata,
  input logic             tick_fast,
  input logic             tick_slow
);
  assert_step_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> (run_en && !suspend_enter));

  assert_step_plus_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

  assert_fast_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fast |-> (timer_rdata[FAST_SPAN_BITS-1:0] == '0));

  assert_fast_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fast |=> !tick_fast);

  assert_slow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> (tick_fast && cnt_val == '0));

  assert_suspend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_enter |=> (cnt_val == '0 && !tick_fast && !tick_slow));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !suspend_enter) |=> ($stable(cnt_val) && !tick_fast && !tick_slow));
endmodule

bind interval_timer interval_timer_sva #(
  .CNT_W(CNT_W), .RD_W(RD_W), .FAST_SPAN_BITS(FAST_SPAN_BITS)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .suspend_enter (suspend_enter),
  .run_en        (run_en),
  .step_evt      (step_evt),
  .cnt_val       (cnt_val),
  .timer_rdata   (timer_rdata),
  .tick_fast     (tick_fast),
  .tick_slow     (tick_slow)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int DIV       = 6;
  localparam int WRAP      = 1024;
  localparam int FAST_CNT  = 128;
  localparam int MAX_CYC   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       suspend_enter = 1'b0;
  logic       run_en = 1'b1;
  logic [7:0] timer_rdata;
  logic       tick_fast;
  logic       tick_slow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state: enabled cycles since the last clear.
  int ecyc = 0;
  bit x_fast = 0;
  bit x_slow = 0;
  int n_fast = 0;
  int n_slow = 0;

  always #2 clk = ~clk;

  interval_timer u_interval_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .suspend_enter (suspend_enter),
    .run_en        (run_en),
    .timer_rdata   (timer_rdata),
    .tick_fast     (tick_fast),
    .tick_slow     (tick_slow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_byte(input int e);
    return ((e / DIV) % WRAP) % 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecyc <= 0; x_fast <= 0; x_slow <= 0;
    end else if (suspend_enter) begin
      ecyc <= 0; x_fast <= 0; x_slow <= 0;
    end else if (run_en) begin
      ecyc   <= ecyc + 1;
      x_fast <= ((ecyc + 1) % (DIV * FAST_CNT)) == 0;
      x_slow <= ((ecyc + 1) % (DIV * WRAP)) == 0;
    end else begin
      x_fast <= 0; x_slow <= 0;
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      chk(timer_rdata == 8'(exp_byte(ecyc)), "R2 count", timer_rdata, exp_byte(ecyc));
      chk(tick_fast == x_fast, "R4 tick_fast", tick_fast, x_fast);
      chk(tick_slow == x_slow, "R5 tick_slow", tick_slow, x_slow);
      if (tick_fast) n_fast++;
      if (tick_slow) n_slow++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] held;
    int f0;
    // R3: reset state
    cycles(3);
    @(negedge clk);
    chk(timer_rdata == 0 && !tick_fast && !tick_slow, "R3 reset", timer_rdata, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: six enabled edges give the first step
    cycles(5);
    @(negedge clk);
    chk(timer_rdata == 0, "R1 before sixth", timer_rdata, 0);
    cycles(1);
    @(negedge clk);
    chk(timer_rdata == 1, "R1 sixth", timer_rdata, 1);
    // R4/R5: run past one full wrap (6144 cycles from clear)
    cycles(6200 - 6);
    @(negedge clk);
    chk(n_fast == 8, "R4 fast count", n_fast, 8);
    chk(n_slow == 1, "R5 slow count", n_slow, 1);
    // R7: freeze
    @(posedge clk); #1;
    run_en = 1'b0;
    @(negedge clk);
    held = timer_rdata;
    f0 = n_fast;
    cycles(50);
    @(negedge clk);
    chk(timer_rdata == held, "R7 frozen", timer_rdata, held);
    chk(n_fast == f0, "R7 no tick", n_fast, f0);
    // R8: resume (model checks the phase every cycle)
    @(posedge clk); #1;
    run_en = 1'b1;
    cycles(20);
    // R6: suspend strobe with run high
    suspend_enter = 1'b1;
    cycles(1);
    suspend_enter = 1'b0;
    @(negedge clk);
    chk(timer_rdata == 0 && !tick_fast, "R6 clear run", timer_rdata, 0);
    cycles(700);
    // R6: suspend strobe with run low
    run_en = 1'b0;
    suspend_enter = 1'b1;
    cycles(1);
    suspend_enter = 1'b0;
    @(negedge clk);
    chk(timer_rdata == 0, "R6 clear frozen", timer_rdata, 0);
    cycles(10);
    @(negedge clk);
    chk(timer_rdata == 0, "R7 held after clear", timer_rdata, 0);
    @(posedge clk); #1;
    run_en = 1'b1;
    cycles(6);
    @(negedge clk);
    chk(timer_rdata == 1, "R8 resume phase", timer_rdata, 1);
    // Mixed gating pattern (R7, R8)
    @(posedge clk); #1;
    for (int i = 0; i < 4000; i++) begin
      run_en = ((i % 7) != 3) && ((i % 13) != 0);
      suspend_enter = (i % 1777) == 1776;
      cycles(1);
    end
    run_en = 1'b1;
    suspend_enter = 1'b0;
    // R3: mid-run asynchronous reset
    cycles(300);
    rst_n = 1'b0;
    #0.5;
    chk(timer_rdata == 0, "R3 async reset", timer_rdata, 0);
    cycles(2);
    rst_n = 1'b1;
    cycles(100);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * MAX_CYC);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule